// File: doc/BRIEF.md
# Two-Channel Interrupt Status and Mask

This block gathers two interrupt sources per channel for two channels: a device interrupt and a bus-master transfer-complete interrupt. It samples them once per clock and shows the sampled values to the host as read-only status bits. Each channel has a mask bit, and each channel drives one interrupt line whose active level is picked by a per-channel polarity input. Status always shows the raw sampled sources. The mask and the polarity only affect the interrupt lines.

The same register window also holds a write-only test/mode register. It sits at the same offset as the channel 0 status. A host read at that offset returns status, and a host write at that offset updates the mode register. A write is accepted only when its top bit is set. A write that fails this rule is dropped and reported on a one-cycle error output. A strap input reports whether a legacy header is fitted, and the host reads it through the mask register.

Top module: `chan_irq_ctrl`

## Requirements
- R1: While and after reset, before any write, the masks and mode bits are 0, `legacyMode`, `testMode` and `wrError` are 0, and each `irqOut` line sits at its inactive level (equal to its `polarityLow` bit).
- R2: A read at offset 2 returns bit 1 = channel 0 bus-master source and bit 0 = channel 0 device source, both as sampled at the last clock edge. Bits 7..2 read 0.
- R3: A read at offset 3 returns bit 4 = `legacyStrap`, bit 3 = channel 1 bus-master source, bit 2 = channel 1 device source (both sampled at the last edge), bit 1 = channel 1 mask and bit 0 = channel 0 mask. Bits 7..5 read 0.
- R4: Status bits show the sampled sources whatever the mask bits hold.
- R5: One cycle after sampling, a channel's line is active exactly when that channel's mask is 0 and at least one of its two sampled sources is 1.
- R6: When `polarityLow[c]` is 1, line c is active low. When it is 0, line c is active high.
- R7: A write at offset 2 with data bit 7 = 1 loads bit 1 into `legacyMode` and bit 0 into `testMode` at the next edge.
- R8: A write at offset 2 with data bit 7 = 0 leaves the mode bits unchanged, and `wrError` is 1 for exactly the next cycle.
- R9: A write at offset 3 changes only the two mask bits (data bits 1..0). Bits 4..2 keep showing the strap and the channel 1 status.
- R10: Reads at offsets 0 and 1 return 0, and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devIrqIn | input | 2 | Device interrupt source per channel |
| dmaIrqIn | input | 2 | Bus-master interrupt source per channel |
| polarityLow | input | 2 | Per-channel line polarity, 1 = active low |
| legacyStrap | input | 1 | Legacy header present strap |
| addr | input | 2 | Register offset for reads and writes |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| irqOut | output | 2 | Per-channel interrupt line |
| legacyMode | output | 1 | Legacy-compatible mode selected |
| testMode | output | 1 | Test mode selected |
| wrError | output | 1 | One-cycle flag after a rejected mode write |

## Verification
The hardest case to reach is a channel with both sources active and its mask set, so that status reads 1 while the line stays inactive. A second hard case is the same-offset split, where a mode write lands while status is being read at offset 2. Random stimulus sets each source bit independently and picks random write data. Mask writes therefore leave channels masked for long runs while sources toggle. Directed steps then mask one channel under active sources, send a rejected mode write and read it back, and write all ones to offset 3 with the strap low.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int NUM_CH   = 2;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = 8;
  localparam logic [ADDR_W-1:0] STAT_OFS = 2'd2;
  localparam logic [ADDR_W-1:0] MASK_OFS = 2'd3;
  localparam int KEY_BIT  = 7;

  typedef struct packed {
    logic wrMode;
    logic wrMask;
    logic badWr;
  } ctlStrobe_t;
endpackage

// File: rtl/chan_irq_decode.sv
module chan_irq_decode
  import chan_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output ctlStrobe_t        strobe
);
  logic hitStat;
  logic hitMask;

  always_comb begin
    hitStat       = wrEn && (addr == STAT_OFS);
    hitMask       = wrEn && (addr == MASK_OFS);
    strobe.wrMode = hitStat && wrData[KEY_BIT];
    strobe.badWr  = hitStat && !wrData[KEY_BIT];
    strobe.wrMask = hitMask;
  end
endmodule

// File: rtl/chan_irq_datapath.sv
module chan_irq_datapath
  import chan_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_CH-1:0] devIrqIn,
  input  logic [NUM_CH-1:0] dmaIrqIn,
  input  logic [NUM_CH-1:0] polarityLow,
  input  logic              legacyStrap,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] irqOut,
  output logic              legacyMode,
  output logic              testMode,
  output logic              wrError
);
  logic [NUM_CH-1:0] devQ;
  logic [NUM_CH-1:0] dmaQ;
  logic [NUM_CH-1:0] maskQ;
  logic [1:0]        modeQ;
  logic              errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devQ  <= '0;
      dmaQ  <= '0;
      maskQ <= '0;
      modeQ <= '0;
      errQ  <= 1'b0;
    end else begin
      devQ <= devIrqIn;
      dmaQ <= dmaIrqIn;
      errQ <= strobe.badWr;
      if (strobe.wrMask) maskQ <= wrData[NUM_CH-1:0];
      if (strobe.wrMode) modeQ <= wrData[1:0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_line
    logic active;
    assign active    = !maskQ[c] && (devQ[c] || dmaQ[c]);
    assign irqOut[c] = active ^ polarityLow[c];
  end

  always_comb begin
    rdData = '0;
    case (addr)
      STAT_OFS: rdData[1:0] = {dmaQ[0], devQ[0]};
      MASK_OFS: rdData[4:0] = {legacyStrap, dmaQ[1], devQ[1], maskQ[1], maskQ[0]};
      default:  rdData = '0;
    endcase
  end

  assign legacyMode = modeQ[1];
  assign testMode   = modeQ[0];
  assign wrError    = errQ;
endmodule

// File: rtl/chan_irq_ctrl.sv
module chan_irq_ctrl
  import chan_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        devIrqIn,
  input  logic [1:0]        dmaIrqIn,
  input  logic [1:0]        polarityLow,
  input  logic              legacyStrap,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic [1:0]        irqOut,
  output logic              legacyMode,
  output logic              testMode,
  output logic              wrError
);
  ctlStrobe_t strobe;

  chan_irq_decode u_decode (
    .addr   (addr),
    .wrEn   (wrEn),
    .wrData (wrData),
    .strobe (strobe)
  );

  chan_irq_datapath u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (wrData),
    .addr        (addr),
    .devIrqIn    (devIrqIn),
    .dmaIrqIn    (dmaIrqIn),
    .polarityLow (polarityLow),
    .legacyStrap (legacyStrap),
    .rdData      (rdData),
    .irqOut      (irqOut),
    .legacyMode  (legacyMode),
    .testMode    (testMode),
    .wrError     (wrError)
  );
endmodule

// File: rtl/chan_irq_checker.sv
module chan_irq_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] devIrqIn,
  input logic [1:0] dmaIrqIn,
  input logic [1:0] polarityLow,
  input logic [1:0] addr,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [1:0] irqOut,
  input logic       legacyMode,
  input logic       testMode,
  input logic       wrError
);
  AST_BAD_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd2 && !wrData[7]) |=> wrError); // R8
  AST_BAD_WRITE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd2 && !wrData[7]) |=> ($stable(legacyMode) && $stable(testMode))); // R8
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd2 && wrData[7]) |=> (legacyMode == $past(wrData[1]) && testMode == $past(wrData[0]))); // R7
  AST_IDLE_CH0_INACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(devIrqIn[0] || dmaIrqIn[0]) |=> (irqOut[0] == polarityLow[0])); // R5
  AST_IDLE_CH1_INACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(devIrqIn[1] || dmaIrqIn[1]) |=> (irqOut[1] == polarityLow[1])); // R6
  AST_LOW_OFFSETS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr < 2'd2) |-> (rdData == 8'h00)); // R10
  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd2) |-> (rdData[7:2] == 6'd0)); // R2
  AST_MASKREG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd3) |-> (rdData[7:5] == 3'd0)); // R3
endmodule

bind chan_irq_ctrl chan_irq_checker u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .devIrqIn    (devIrqIn),
  .dmaIrqIn    (dmaIrqIn),
  .polarityLow (polarityLow),
  .addr        (addr),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .rdData      (rdData),
  .irqOut      (irqOut),
  .legacyMode  (legacyMode),
  .testMode    (testMode),
  .wrError     (wrError)
);

// File: tb/sim_chan_irq_ctrl.sv
`timescale 1ns/1ps
module sim_chan_irq_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] devIrqIn = '0;
  logic [1:0] dmaIrqIn = '0;
  logic [1:0] polarityLow = '0;
  logic       legacyStrap = 1'b0;
  logic [1:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [1:0] irqOut;
  logic       legacyMode;
  logic       testMode;
  logic       wrError;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [1:0] mDev = '0, mDma = '0, mMask = '0, mMode = '0;
  logic       mErr = 1'b0;

  always #2.5 clk = ~clk;

  chan_irq_ctrl u0 (.*);

  function automatic logic [7:0] expRead(input logic [1:0] a, input logic strap);
    case (a)
      2'd2:    return {6'd0, mDma[0], mDev[0]};
      2'd3:    return {3'd0, strap, mDma[1], mDev[1], mMask};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [1:0] expIrq(input logic [1:0] pol);
    logic [1:0] r;
    for (int c = 0; c < 2; c++) r[c] = (!mMask[c] && (mDev[c] || mDma[c])) ^ pol[c];
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll();
    string rtag;
    rtag = (addr == 2'd2) ? "R2 status read" : (addr == 2'd3) ? "R3 mask reg read" : "R10 low offset read";
    check(rtag, rdData, expRead(addr, legacyStrap));
    check((polarityLow != 2'b00) ? "R6 line polarity" : "R5 line level", {6'd0, irqOut}, {6'd0, expIrq(polarityLow)});
    check("R7 mode bits", {6'd0, legacyMode, testMode}, {6'd0, mMode});
    check("R8 write error flag", {7'd0, wrError}, {7'd0, mErr});
  endtask

  task automatic step(input logic [1:0] dv, input logic [1:0] dm, input logic [1:0] pol,
                      input logic strap, input logic [1:0] a, input logic we, input logic [7:0] wd);
    @(negedge clk);
    devIrqIn = dv; dmaIrqIn = dm; polarityLow = pol; legacyStrap = strap;
    addr = a; wrEn = we; wrData = wd;
    mDev = dv; mDma = dm;
    mErr = we && a == 2'd2 && !wd[7];
    if (we && a == 2'd2 && wd[7]) mMode = wd[1:0];
    if (we && a == 2'd3) mMask = wd[1:0];
    @(posedge clk);
    #1;
    checkAll();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd7331);
    polarityLow = 2'b10;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state, lines inactive under chosen polarity
    check("R1 reset mode", {6'd0, legacyMode, testMode}, 8'h00);
    check("R1 reset error", {7'd0, wrError}, 8'h00);
    check("R1 reset lines", {6'd0, irqOut}, 8'h02);
    addr = 2'd3; #1;
    check("R1 reset masks", rdData, 8'h00);
    @(negedge clk); rstN = 1'b1;

    // R4: masked channel still shows status, line inactive
    step(2'b01, 2'b01, 2'b00, 1'b0, 2'd3, 1'b1, 8'h01);
    step(2'b11, 2'b11, 2'b00, 1'b0, 2'd2, 1'b0, 8'h00);
    check("R4 status under mask", rdData, 8'h03);
    check("R4 masked line idle", {6'd0, irqOut}, 8'h02);
    // R8: rejected write then read back mode
    step(2'b00, 2'b00, 2'b00, 1'b0, 2'd2, 1'b1, 8'h83);
    step(2'b00, 2'b00, 2'b00, 1'b0, 2'd2, 1'b1, 8'h00);
    check("R8 mode kept", {6'd0, legacyMode, testMode}, 8'h03);
    check("R8 flag", {7'd0, wrError}, 8'h01);
    step(2'b00, 2'b00, 2'b00, 1'b0, 2'd2, 1'b0, 8'h00);
    check("R8 flag one cycle", {7'd0, wrError}, 8'h00);
    // R9: all-ones write to offset 3, strap low, channel 1 idle
    step(2'b00, 2'b00, 2'b00, 1'b0, 2'd3, 1'b1, 8'hFF);
    check("R9 only masks change", rdData, 8'h03);
    // R10: writes to low offsets change nothing
    step(2'b00, 2'b00, 2'b00, 1'b1, 2'd0, 1'b1, 8'hFF);
    step(2'b00, 2'b00, 2'b00, 1'b1, 2'd1, 1'b1, 8'h00);
    step(2'b00, 2'b00, 2'b00, 1'b1, 2'd3, 1'b0, 8'h00);
    check("R10 low writes ignored", rdData, 8'h13);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] wd;
      wd = 8'($urandom);
      if ($urandom % 2 == 0) wd[7] = 1'b1;
      step(2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
           2'($urandom), ($urandom % 3 == 0), wd);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule